// File: doc/BRIEF.md
# Multi-Socket Indexed Register File

This block is the host-side register file of a card-socket bridge that serves up to four card sockets. The host sees a two-byte I/O aperture: offset 0 takes a register index and offset 1 moves a data byte to or from the register that the index names. The index stays put between data accesses. A read-modify-write of one register therefore needs a single index write.

The index splits into two parts. The upper two bits choose the socket and the lower six bits choose the register within it, so each socket owns a stride of 0x40 indices. Each socket has these registers:
- a status byte sampled from the socket pins through a two-stage synchronizer;
- an interrupt/general control byte that drives the card reset line and the I/O-card mode;
- a power control byte;
- a 16-bit window enable register stored as two bytes.

A global configuration byte, loaded from a separate configuration port, sets how many sockets are enabled. Sockets beyond that count read as zero, ignore writes and hold their card-side outputs inactive.

Host requests travel on a valid/ready channel. Read data returns one cycle after acceptance on a valid/ready response channel. A read response the host has not taken blocks further requests, and a new read can never overwrite it. Writes complete in the cycle they are accepted and produce no response.

Top module: `sockreg_file`

## Requirements
- R1: A request accepted at offset 0 with write set loads the 8-bit index. A read at offset 0 returns the index. The index keeps its value across any number of data-port accesses.
- R2: A data-port access addresses register `idx[5:0]` of socket `idx[7:6]`, so socket n's register r sits at index r + n*0x40. Writes to one socket leave every other socket unchanged. Register numbers are 0x02 control, 0x03 power, 0x04 window low byte and 0x05 window high byte, all read/write. Register 0x00 and registers 0x06 to 0x3F read 0x00.
- R3: The 16-bit window enable register is stored low byte at 0x04 and high byte at 0x05. Each byte is written and read independently.
- R4: Configuration bits [2:1] set the enabled socket count: 00 enables sockets 0 and 1, 01 enables socket 0 only, and 10 or 11 enables all four. Bits [7:3] and [0] are stored and returned on `cfg_q` with no other effect.
- R5: A data access to a socket beyond the enabled count reads 0x00 and its writes are ignored. That socket's stored registers keep their values and become visible again once the socket is enabled.
- R6: Status register 0x01 reads {0, pins[6:0]} of the socket, taken through two synchronizing flops. Writes to it are ignored.
- R7: `card_present[n]` is high exactly when socket n is enabled and its synchronized status bits 2 and 3 are both 1.
- R8: `card_rst_n[n]` follows control bit 6 of an enabled socket. A 0 in that bit holds the card in reset, and a disabled socket is always held in reset.
- R9: Control bit 5 selects I/O-card mode. With bit 5 = 0, `batt_dead` = ~status[0], `batt_warn` = ~status[1] and `stat_chg` = 0. With bit 5 = 1, `stat_chg` = ~status[0] and both battery outputs are 0. A disabled socket drives all three low.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_data` is held stable.
- R11: A synchronous reset clears the index, the configuration, every socket register and the response channel to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | Aperture offset: 0 = index port, 1 = data port |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the read response |
| rsp_data | output | 8 | Read response byte |
| cfg_we | input | 1 | Load the configuration byte |
| cfg_wdata | input | 8 | Configuration byte |
| cfg_q | output | 8 | Stored configuration byte |
| sock_stat | input | 28 | Status pins, 7 per socket, socket n at [7n+6:7n] |
| card_present | output | 4 | Card detected per socket |
| card_rst_n | output | 4 | Card reset per socket, active low |
| batt_dead | output | 4 | Battery-dead indication per socket |
| batt_warn | output | 4 | Battery-warning indication per socket |
| stat_chg | output | 4 | I/O-card status-change indication per socket |

## Verification
The hardest case to reach is a disabled socket's stored registers surviving ignored writes and then reappearing intact. This can only be seen after the configuration changes back. The bench sweeps several configuration values in turn. Under each value it writes every register index of all four sockets and reads them all back, checking against a model that accepts a write only when the socket is enabled. Stale values written under an earlier count must show up, or stay hidden, under the next one. The blocked-response case is reached by holding `rsp_ready` low after a read.

// File: rtl/sockreg_pkg.sv
package sockreg_pkg;

  localparam int IDX_W    = 8;
  localparam int STRIDE_W = 6;
  localparam int STAT_W   = 7;

  localparam logic [STRIDE_W-1:0] REG_STAT  = 6'h01;
  localparam logic [STRIDE_W-1:0] REG_CTRL  = 6'h02;
  localparam logic [STRIDE_W-1:0] REG_PWR   = 6'h03;
  localparam logic [STRIDE_W-1:0] REG_WINLO = 6'h04;
  localparam logic [STRIDE_W-1:0] REG_WINHI = 6'h05;

  localparam int CTRL_RSTN_BIT = 6;
  localparam int CTRL_IOM_BIT  = 5;

  // enabled-socket mask from configuration bits [2:1]
  function automatic logic [3:0] count_mask(input logic [1:0] sel);
    logic [3:0] m;
    case (sel)
      2'b00:   m = 4'b0011;
      2'b01:   m = 4'b0001;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sockreg_decode.sv
module sockreg_decode #(
  parameter int NSOCK    = 4,
  parameter int IDX_W    = 8,
  parameter int STRIDE_W = 6
) (
  input  logic [IDX_W-1:0]    idx,
  input  logic [NSOCK-1:0]    en_mask,
  output logic [NSOCK-1:0]    sock_sel,
  output logic [STRIDE_W-1:0] reg_num,
  output logic                hit
);
  localparam int SOCK_W = IDX_W - STRIDE_W;

  logic [SOCK_W-1:0] sock_num;

  assign sock_num = idx[IDX_W-1:STRIDE_W];
  assign reg_num  = idx[STRIDE_W-1:0];

  for (genvar g = 0; g < NSOCK; g++) begin : g_sel
    assign sock_sel[g] = (sock_num == SOCK_W'(g)) && en_mask[g];
  end

  assign hit = |sock_sel;
endmodule

// File: rtl/sockreg_slot.sv
module sockreg_slot
  import sockreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                wr,
  input  logic [STRIDE_W-1:0] reg_num,
  input  logic [7:0]          wdata,
  input  logic [STAT_W-1:0]   pins,
  output logic [7:0]          rdata,
  output logic                present,
  output logic                rst_n,
  output logic                bdead,
  output logic                bwarn,
  output logic                schg
);
  logic [STAT_W-1:0] sync_q [SYNC_STAGES];
  logic [STAT_W-1:0] stat;
  logic [7:0]  ctrl_q, pwr_q;
  logic [15:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= pins;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end
  assign stat = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pwr_q  <= '0;
      win_q  <= '0;
    end else if (wr) begin
      case (reg_num)
        REG_CTRL:  ctrl_q       <= wdata;
        REG_PWR:   pwr_q        <= wdata;
        REG_WINLO: win_q[7:0]   <= wdata;
        REG_WINHI: win_q[15:8]  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_num)
      REG_STAT:  rdata = {1'b0, stat};
      REG_CTRL:  rdata = ctrl_q;
      REG_PWR:   rdata = pwr_q;
      REG_WINLO: rdata = win_q[7:0];
      REG_WINHI: rdata = win_q[15:8];
      default:   rdata = 8'h00;
    endcase
  end

  logic iomode;
  assign iomode  = ctrl_q[CTRL_IOM_BIT];
  assign present = en && stat[2] && stat[3];
  assign rst_n   = en && ctrl_q[CTRL_RSTN_BIT];
  assign bdead   = en && !iomode && !stat[0];
  assign bwarn   = en && !iomode && !stat[1];
  assign schg    = en &&  iomode && !stat[0];
endmodule

// File: rtl/sockreg_file.sv
module sockreg_file
  import sockreg_pkg::*;
#(
  parameter int NSOCK       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic                    req_addr,
  input  logic [7:0]              req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [7:0]              rsp_data,
  input  logic                    cfg_we,
  input  logic [7:0]              cfg_wdata,
  output logic [7:0]              cfg_q,
  input  logic [NSOCK*STAT_W-1:0] sock_stat,
  output logic [NSOCK-1:0]        card_present,
  output logic [NSOCK-1:0]        card_rst_n,
  output logic [NSOCK-1:0]        batt_dead,
  output logic [NSOCK-1:0]        batt_warn,
  output logic [NSOCK-1:0]        stat_chg
);
  logic [IDX_W-1:0]    idx_q;
  logic [NSOCK-1:0]    en_mask, sock_sel;
  logic [STRIDE_W-1:0] reg_num;
  logic                hit, acc, data_wr;
  logic [7:0]          slot_rd [NSOCK];
  logic [7:0]          data_rd;

  assign en_mask   = NSOCK'(count_mask(cfg_q[2:1]));
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign data_wr   = acc && req_write && req_addr;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (acc && req_write && !req_addr) idx_q <= req_wdata;
  end

  sockreg_decode #(.NSOCK(NSOCK), .IDX_W(IDX_W), .STRIDE_W(STRIDE_W)) u_dec (
    .idx(idx_q), .en_mask(en_mask), .sock_sel(sock_sel),
    .reg_num(reg_num), .hit(hit)
  );

  for (genvar g = 0; g < NSOCK; g++) begin : g_slot
    sockreg_slot #(.SYNC_STAGES(SYNC_STAGES)) u_slot (
      .clk(clk), .rst(rst), .en(en_mask[g]),
      .wr(data_wr && sock_sel[g]), .reg_num(reg_num), .wdata(req_wdata),
      .pins(sock_stat[g*STAT_W +: STAT_W]), .rdata(slot_rd[g]),
      .present(card_present[g]), .rst_n(card_rst_n[g]),
      .bdead(batt_dead[g]), .bwarn(batt_warn[g]), .schg(stat_chg[g])
    );
  end

  always_comb begin
    data_rd = 8'h00;
    for (int i = 0; i < NSOCK; i++)
      if (sock_sel[i]) data_rd = data_rd | slot_rd[i];
    if (!hit) data_rd = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= req_addr ? data_rd : idx_q;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sockreg_file_chk.sv
module sockreg_file_chk #(
  parameter int NSOCK = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             req_addr,
  input logic [7:0]       req_wdata,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [7:0]       rsp_data,
  input logic [7:0]       idx_q,
  input logic [NSOCK-1:0] card_rst_n,
  input logic [NSOCK-1:0] batt_dead,
  input logic [NSOCK-1:0] batt_warn,
  input logic [NSOCK-1:0] stat_chg
);
  a_r1_index_load: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write && !req_addr) |=> idx_q == $past(req_wdata));

  a_r10_block_req: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r9_mode_excl: assert property (@(posedge clk) disable iff (rst)
    ((batt_dead | batt_warn) & stat_chg) == '0);

  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> (!rsp_valid && idx_q == 8'h00 && card_rst_n == '0));
endmodule

bind sockreg_file sockreg_file_chk #(.NSOCK(NSOCK)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .idx_q(idx_q), .card_rst_n(card_rst_n), .batt_dead(batt_dead),
  .batt_warn(batt_warn), .stat_chg(stat_chg)
);

// File: tb/sockreg_file_test.sv
module sockreg_file_test;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst, req_valid, req_ready, req_write, req_addr, rsp_valid, rsp_ready, cfg_we;
  logic [7:0] req_wdata, rsp_data, cfg_wdata, cfg_q;
  logic [27:0] sock_stat;
  logic [3:0] card_present, card_rst_n, batt_dead, batt_warn, stat_chg;

  sockreg_file uut (.*);

  int nvec = 0, nbad = 0;
  logic [7:0] model [4][6];
  logic [6:0] pins [4];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic a, input logic w, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    q = rsp_data;
  endtask

  function automatic logic [3:0] mask_of(logic [7:0] c);
    return (c[2:1] == 2'b00) ? 4'b0011 : (c[2:1] == 2'b01) ? 4'b0001 : 4'b1111;
  endfunction

  task automatic set_cfg(input logic [7:0] c);
    @(negedge clk); cfg_we = 1; cfg_wdata = c;
    @(negedge clk); cfg_we = 0;
  endtask

  logic [7:0] q;
  logic [7:0] cfgs [5] = '{8'h00, 8'h02, 8'h04, 8'h06, 8'hF9};

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst = 1; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    rsp_ready = 1; cfg_we = 0; cfg_wdata = 0;
    pins[0] = 7'h0C; pins[1] = 7'h06; pins[2] = 7'h7F; pins[3] = 7'h0E;
    sock_stat = {pins[3], pins[2], pins[1], pins[0]};
    for (int s = 0; s < 4; s++) for (int r = 0; r < 6; r++) model[s][r] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R11: reset state
    check("R11 rsp_valid", rsp_valid, 0);
    check("R11 cfg_q", cfg_q, 0);
    check("R11 card_rst_n", card_rst_n, 0);
    bus(0, 0, 0, q); check("R11 index", q, 0);
    repeat (4) @(negedge clk);

    foreach (cfgs[ci]) begin
      logic [3:0] m;
      set_cfg(cfgs[ci]);
      m = mask_of(cfgs[ci]);
      check("R4 cfg_q", cfg_q, cfgs[ci]);
      for (int s = 0; s < 4; s++)
        for (int r = 0; r < 8; r++) begin
          logic [7:0] v;
          v = 8'((ci * 37 + s * 11 + r * 5) ^ 8'h5A);
          if (r == 2) v[6] = s[0] ^ ci[0];
          bus(0, 1, 8'(s * 64 + r), q);
          bus(1, 1, v, q);
          if (m[s] && r >= 2 && r <= 5) model[s][r] = v;
        end
      for (int s = 0; s < 4; s++)
        for (int r = 0; r < 8; r++) begin
          logic [7:0] e;
          e = 0;
          if (m[s]) begin
            if (r == 1) e = {1'b0, pins[s]};
            else if (r >= 2 && r <= 5) e = model[s][r];
          end
          bus(0, 1, 8'(s * 64 + r), q);
          bus(1, 0, 0, q);
          if (!m[s]) check("R5 disabled socket reads zero", q, e);
          else if (r == 1) check("R6 status", q, e);
          else if (r == 4 || r == 5) check("R3 window byte", q, e);
          else check("R2 register", q, e);
        end
      for (int s = 0; s < 4; s++) begin
        logic pr, iom;
        pr = m[s] && pins[s][2] && pins[s][3];
        iom = model[s][2][5];
        check("R7 card_present", card_present[s], pr);
        check("R8 card_rst_n", card_rst_n[s], m[s] && model[s][2][6]);
        check("R9 batt_dead", batt_dead[s], m[s] && !iom && !pins[s][0]);
        check("R9 batt_warn", batt_warn[s], m[s] && !iom && !pins[s][1]);
        check("R9 stat_chg", stat_chg[s], m[s] && iom && !pins[s][0]);
      end
    end

    // R1: index readback and held across data accesses (read-modify-write)
    set_cfg(8'h04);
    bus(0, 1, 8'hC3, q);
    bus(0, 0, 0, q); check("R1 index readback", q, 8'hC3);
    bus(1, 0, 0, q); check("R1 rmw read", q, model[3][3]);
    bus(1, 1, q | 8'h81, q);
    bus(1, 0, 0, q); check("R1 rmw write w/o index", q, model[3][3] | 8'h81);
    bus(0, 0, 0, q); check("R1 index held", q, 8'hC3);

    // R6: status write ignored, pin change after sync
    pins[1] = 7'h3C; sock_stat[13:7] = pins[1];
    bus(0, 1, 8'h41, q);
    bus(1, 1, 8'hFF, q);
    repeat (3) @(negedge clk);
    bus(1, 0, 0, q); check("R6 status after pin change", q, 8'h3C);
    check("R7 card_present after pin change", card_present[1], 1);

    // R10: back-pressure on the response
    bus(0, 1, 8'h03, q);
    @(negedge clk); rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 1;
    @(negedge clk); req_valid = 0;
    check("R10 rsp_valid held", rsp_valid, 1);
    check("R10 req_ready low", req_ready, 0);
    q = rsp_data;
    repeat (3) @(negedge clk);
    check("R10 rsp_data stable", rsp_data, q);
    check("R10 rsp_data value", q, model[0][3]);
    rsp_ready = 1;
    @(negedge clk);
    check("R10 rsp released", rsp_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule